// File: doc/BRIEF.md
# USB Endpoint Interrupt Status Controller

This block gathers service events from the eight endpoints of a USB device controller into one status register. It turns them into a single level-sensitive interrupt request for the processor. Each endpoint owns one status bit. The bit latches when that endpoint's event occurs and its mask bit is clear. A set mask bit keeps the status bit from latching at all; the mask does not merely hide a latched bit from the output.

Endpoint 0 has three event sources, all taken from its control/status flags:
- the OUT-ready flag rising;
- the IN-ready flag falling;
- the sent-STALL flag rising.

Detecting edges means that a flag which stays high does not set the bit again straight after software has cleared it. Endpoint 1 is driven by a transmit-complete pulse. Endpoints 2 to 7 take generic event pulses. Software reads the status register through a simple register bus. It clears bits by writing ones, and it reads and writes the mask register as a plain register.

Top module: `usb_ep_irq_ctrl`

## Requirements
- R1: Status bit n (n = 0..7) belongs to endpoint n. Register bits 31:8 of both registers always read 0, and writes to them are ignored.
- R2: After reset the status register reads 0x00, the mask register reads 0xFF and the interrupt output is low.
- R3: An event on an endpoint whose mask bit is 1 never sets its status bit. Clearing the mask later does not bring back that lost event.
- R4: A write to the status register (address 0) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: The interrupt output is a register holding the OR of the status bits. It rises one clock after a bit latches and falls one clock after the last set bit is cleared.
- R6: Status bit 0 is set by a rising OUT-ready flag, a falling IN-ready flag or a rising sent-STALL flag. A flag that holds steady, at either level, sets nothing.
- R7: Status bit 1 is set in every cycle in which the transmit-complete input is high. Status bit k (k = 2..7) is set in every cycle in which event input bit k-2 is high.
- R8: When an event and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R9: The mask register sits at address 1 and is read/write. Every other address reads 0. Read data appears on the output in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address (0 status, 1 mask) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ep0_out_rdy | input | 1 | Endpoint 0 OUT-packet-ready flag |
| ep0_in_rdy | input | 1 | Endpoint 0 IN-packet-ready flag |
| ep0_stall_sent | input | 1 | Endpoint 0 sent-STALL flag |
| ep1_tx_done | input | 1 | Endpoint 1 transmit-complete pulse |
| ep_evt | input | 6 | Event pulses for endpoints 2..7 (bit 0 = endpoint 2) |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
The endpoint 0 flags are driven through edges and through steady levels held across a clear. This separates true edge detection from level sampling, and it catches the IN-ready polarity. The pulse inputs are tried one at a time and then all together under a mixed mask pattern. This shows that each source maps to the right bit and that masking is applied per bit. The tests also use clear writes with wrong-bit and all-ones patterns, a clear that coincides with an event, and interrupt samples taken one cycle apart. Together these separate write-1-to-clear from plain writes, set-wins from clear-wins, and a registered interrupt from a combinational one.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned REG_STATUS = 0;
  localparam int unsigned REG_MASK   = 1;
endpackage

// File: rtl/usb_ep0_evt_det.sv
module usb_ep0_evt_det (
  input  logic clk,
  input  logic rst,
  input  logic out_rdy,
  input  logic in_rdy,
  input  logic stall_sent,
  output logic evt
);
  logic out_q, in_q, stall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= 1'b0;
      in_q    <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      out_q   <= out_rdy;
      in_q    <= in_rdy;
      stall_q <= stall_sent;
    end
  end

  assign evt = (out_rdy & ~out_q) | (~in_rdy & in_q) | (stall_sent & ~stall_q);

  // R6: steady flags raise no event
  a_r6_steady_no_evt: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(out_rdy) && $stable(in_rdy) && $stable(stall_sent)) |-> !evt);
endmodule

// File: rtl/usb_irq_stat_bit.sv
module usb_irq_stat_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic mask,
  input  logic clr,
  output logic st
);
  always_ff @(posedge clk) begin
    if (rst) st <= 1'b0;
    else     st <= (set_ev & ~mask) | (st & ~clr);
  end

  a_r3_masked_no_set: assert property (@(posedge clk) disable iff (rst)
    (mask && !st) |=> !st);
  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !set_ev && st) |=> !st);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_ev && !mask) |=> st);
endmodule

// File: rtl/usb_irq_regif.sv
module usb_irq_regif #(
  parameter int unsigned NUM_EP = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NUM_EP-1:0] status,
  output logic [NUM_EP-1:0] mask,
  output logic [NUM_EP-1:0] clr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import usb_irq_pkg::*;
  localparam int unsigned PAD_W = DATA_W - NUM_EP;

  logic sel_stat, sel_mask;
  logic unused_hi;

  assign sel_stat  = (bus_addr == ADDR_W'(REG_STATUS));
  assign sel_mask  = (bus_addr == ADDR_W'(REG_MASK));
  assign clr       = (bus_wr && sel_stat) ? bus_wdata[NUM_EP-1:0] : '0;
  assign unused_hi = ^bus_wdata[DATA_W-1:NUM_EP];

  always_ff @(posedge clk) begin
    if (rst)                    mask <= '1;
    else if (bus_wr && sel_mask) mask <= bus_wdata[NUM_EP-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      if (sel_stat)      bus_rdata <= {{PAD_W{1'b0}}, status};
      else if (sel_mask) bus_rdata <= {{PAD_W{1'b0}}, mask};
      else               bus_rdata <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |status;
  end

  a_r5_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|status)));
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:NUM_EP] == '0);
  a_r2_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (mask == '1 && !irq));
endmodule

// File: rtl/usb_ep_irq_ctrl.sv
module usb_ep_irq_ctrl #(
  parameter int unsigned NUM_EP = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ep0_out_rdy,
  input  logic              ep0_in_rdy,
  input  logic              ep0_stall_sent,
  input  logic              ep1_tx_done,
  input  logic [NUM_EP-3:0] ep_evt,
  output logic              irq
);
  logic [NUM_EP-1:0] src_ev, status, mask, clr;
  logic              ep0_evt;

  usb_ep0_evt_det u_ep0 (
    .clk        (clk),
    .rst        (rst),
    .out_rdy    (ep0_out_rdy),
    .in_rdy     (ep0_in_rdy),
    .stall_sent (ep0_stall_sent),
    .evt        (ep0_evt)
  );

  assign src_ev = {ep_evt, ep1_tx_done, ep0_evt};

  for (genvar i = 0; i < NUM_EP; i++) begin : g_bit
    usb_irq_stat_bit u_bit (
      .clk    (clk),
      .rst    (rst),
      .set_ev (src_ev[i]),
      .mask   (mask[i]),
      .clr    (clr[i]),
      .st     (status[i])
    );
  end

  usb_irq_regif #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status    (status),
    .mask      (mask),
    .clr       (clr),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );
endmodule

// File: tb/usb_ep_irq_ctrl_tb.sv
module usb_ep_irq_ctrl_tb;
  logic        clk = 0, rst = 1;
  logic        bus_rd = 0, bus_wr = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        ep0_out_rdy = 0, ep0_in_rdy = 0, ep0_stall_sent = 0, ep1_tx_done = 0;
  logic [5:0]  ep_evt = 0;
  logic        irq;
  int          n_chk = 0, n_err = 0;
  logic        rd_d = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  always #10 clk = ~clk;

  usb_ep_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ep0_out_rdy(ep0_out_rdy),
    .ep0_in_rdy(ep0_in_rdy), .ep0_stall_sent(ep0_stall_sent),
    .ep1_tx_done(ep1_tx_done), .ep_evt(ep_evt), .irq(irq)
  );

  always @(posedge clk) rd_d <= bus_rd;

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (bus_rdata !== e) begin
        n_err++;
        $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_rd = 1; bus_addr = a;
    cyc();
    bus_rd = 0;
    cyc();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq !== e) begin
      n_err++;
      $display("FAIL %s: irq=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic pulse_evt(input logic [5:0] v);
    ep_evt = v; cyc(); ep_evt = 0;
  endtask

  initial begin
    cyc(5);
    rst = 0;
    cyc();
    chk_irq(0, "R2 irq after reset");
    rd(0, 32'h0, "R2 status after reset");
    rd(1, 32'hFF, "R2 mask after reset");

    // R3: events while masked are lost
    pulse_evt(6'h3F);
    ep1_tx_done = 1; ep0_stall_sent = 1; cyc(); ep1_tx_done = 0;
    rd(0, 32'h0, "R3 masked events");
    chk_irq(0, "R3 irq masked");
    wr(1, 32'h0);
    rd(1, 32'h0, "R9 mask write");
    rd(0, 32'h0, "R3 unmask no late set");

    // R7 + R5 timing
    ep1_tx_done = 1; cyc(); ep1_tx_done = 0;
    chk_irq(0, "R5 irq one cycle late");
    cyc();
    chk_irq(1, "R5 irq rises");
    rd(0, 32'h02, "R7 ep1 bit");
    wr(0, 32'h01);
    rd(0, 32'h02, "R4 zero bits kept");
    wr(0, 32'h02);
    chk_irq(1, "R5 irq falls one cycle late");
    cyc();
    chk_irq(0, "R5 irq low");
    rd(0, 32'h0, "R4 cleared");

    // R7 generic inputs
    pulse_evt(6'h20);
    pulse_evt(6'h01);
    rd(0, 32'h84, "R7 ep7 and ep2");
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h0, "R4 clear all");

    // R6 endpoint 0 conditions (stall held from earlier: no new edge)
    ep0_stall_sent = 0; cyc();
    rd(0, 32'h0, "R6 stall fall no set");
    ep0_out_rdy = 1; cyc();
    rd(0, 32'h01, "R6 out rising");
    wr(0, 32'h01); cyc(3);
    rd(0, 32'h0, "R6 out held no reset");
    ep0_out_rdy = 0; cyc();
    ep0_in_rdy = 1; cyc(2);
    rd(0, 32'h0, "R6 in rise no set");
    ep0_in_rdy = 0; cyc();
    rd(0, 32'h01, "R6 in falling");
    wr(0, 32'h01); cyc(2);
    rd(0, 32'h0, "R6 in low held");
    ep0_stall_sent = 1; cyc();
    rd(0, 32'h01, "R6 stall rising");
    wr(0, 32'h01);

    // R8 set wins
    ep_evt = 6'h02; bus_wr = 1; bus_addr = 0; bus_wdata = 32'h08;
    cyc();
    ep_evt = 0; bus_wr = 0;
    rd(0, 32'h08, "R8 set wins");
    wr(0, 32'h08);

    // R1 reserved bits, R9 mask pattern, R3 per bit
    wr(1, 32'hFFFF_FF00);
    rd(1, 32'h0, "R1 reserved write ignored");
    wr(1, 32'h0000_00A5);
    rd(1, 32'hA5, "R9 mask readback");
    ep0_stall_sent = 0; cyc();
    ep0_stall_sent = 1; ep1_tx_done = 1; ep_evt = 6'h3F;
    cyc();
    ep1_tx_done = 0; ep_evt = 0;
    rd(0, 32'h5A, "R3 per-bit mask");
    rd(2, 32'h0, "R9 unmapped address");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule